// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block sits between a byte-wide host bus and three counter channels of an interval timer. It owns every piece of state that the host sees: per-channel configuration (access width, operating mode, decimal flag), the pointers that sequence two-byte transfers, the frozen count snapshots and the latched status bytes. It delivers to each channel a 16-bit reload value with a one-cycle load pulse, plus the configured operating mode. It takes back each channel's live count and output level. The counting itself happens elsewhere.

The host uses four addresses. Addresses 0, 1 and 2 reach the channel data ports and address 3 is the command port. A command byte either reconfigures one channel, freezes one channel's count, or (with selector 11) issues a multi-channel capture of counts and/or status. Reads are registered, so the byte appears on the read bus in the cycle after the read strobe.

Top module: `tmr_host_if`

## Requirements
- R1: After reset, every channel is in two-byte access (code 11), operating mode 000 and binary counting. The read bus shows 0x00, no load pulse is active and every mode output is 000.
- R2: A write to address 3 with bits 7:6 = channel (00, 01, 10) and bits 5:4 non-zero stores bits 5:4 as the access width, bits 3:1 as the operating mode and bit 0 as the decimal flag of that channel only. The stored mode appears on that channel's mode output.
- R3: Operating mode codes 110 and 111 are stored, output and reported as 010 and 011.
- R4: In two-byte access, data writes alternate. The first byte is held with no load pulse. The second byte loads {second, first} with a one-cycle load pulse on that channel, seen the cycle after the write.
- R5: In low-only access (01), a write loads {0x00, byte}. In high-only access (10), a write loads {byte, 0x00}. Each such write gives one load pulse on that channel only.
- R6: A command with bits 5:4 = 00 freezes the channel's live count. Later reads return the frozen value in the channel's access format: low, then high for code 11. After that, reads return the live count again.
- R7: A count-freeze command is ignored while the channel still holds a frozen count that has not been fully read.
- R8: A read from a channel returns a pending status byte first, then a pending frozen count, then the live count.
- R9: Command selector 11 is a capture command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 freezes their counts and bit 4 = 0 latches their status. Channels that are not selected are unaffected.
- R10: The status byte is {output level, 0, access[1:0], mode[2:0], decimal flag}. A status capture is ignored while an earlier status byte is still unread.
- R11: Without a pending snapshot, a read returns the live low byte in access 01 and the live high byte in access 10. In access 11 it alternates between low and high, starting with low.
- R12: A read of address 3 returns 0xFF and changes no channel state.
- R13: Reconfiguring a channel resets both of its byte pointers to the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Register address: channel data ports 0..NCH-1, command port NCH |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| ld_value | output | NCH*16 | Reload value per channel |
| ld_strobe | output | NCH | One-cycle reload pulse per channel |
| ld_mode | output | NCH*3 | Configured operating mode per channel |
| live_count | input | NCH*16 | Current count of each channel |
| cnt_out | input | NCH | Current output level of each channel |

## Verification
On every cycle, the embedded properties check these rules:
- A load pulse only ever follows a data write to that channel.
- The first half of a two-byte write never produces a pulse.
- Configuration changes only after a configure command.
- A pending count snapshot or status byte survives a repeated capture unchanged.
- Reading a pending status byte consumes the status and leaves the count snapshot in place.
- Address 3 reads as 0xFF.

The byte values that actually come back need the bench's scenarios. These include the low/high ordering of snapshots, the alternation of live reads, the mode aliasing seen through status, multi-channel captures, and the pointer reset on reconfiguration.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  // Access width code; the same encoding doubles as the snapshot read state.
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  typedef struct packed {
    logic              prog;
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
    logic              latch_cnt;
    logic              latch_sts;
  } chan_cmd_t;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [BYTE_W-1:0]      bus_wdata,
  output chan_cmd_t [NCH-1:0]    cmd
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  logic              ctl_wr;
  logic [1:0]        sel;
  logic              capture;
  acc_e              acc;
  logic [MODE_W-1:0] mode_norm;

  always_comb begin
    ctl_wr    = bus_wr && (bus_addr == CTRL_ADDR);
    sel       = bus_wdata[7:6];
    capture   = (sel == 2'b11);
    acc       = acc_e'(bus_wdata[5:4]);
    // codes 11x fold onto 01x
    mode_norm = (bus_wdata[3] && bus_wdata[2]) ? {1'b0, bus_wdata[2:1]} : bus_wdata[3:1];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_cmd_t c;
    logic      direct;
    logic      picked;
    always_comb begin
      direct      = ctl_wr && !capture && (sel == 2'(g));
      picked      = ctl_wr && capture && bus_wdata[g+1];
      c.prog      = direct && (acc != ACC_LATCH);
      c.acc       = acc;
      c.mode      = mode_norm;
      c.bcd       = bus_wdata[0];
      c.latch_cnt = (direct && (acc == ACC_LATCH)) || (picked && !bus_wdata[5]);
      c.latch_sts = picked && !bus_wdata[4];
    end
    assign cmd[g] = c;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cmd_t         cmd,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_count,
  input  logic              cnt_out,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  ld_value,
  output logic              ld_strobe,
  output logic [MODE_W-1:0] ld_mode
);
  acc_e              acc_q, acc_n;
  logic [MODE_W-1:0] mode_q, mode_n;
  logic              bcd_q, bcd_n;
  logic              wr_hi_q, wr_hi_n;
  logic              rd_hi_q, rd_hi_n;
  logic [BYTE_W-1:0] wlo_q, wlo_n;
  logic              wlo_en;
  logic [CNT_W-1:0]  snap_q, snap_n;
  logic              snap_en;
  acc_e              lat_q, lat_n;
  logic              sts_v_q, sts_v_n;
  logic [BYTE_W-1:0] sts_q, sts_n;
  logic              sts_en;
  logic [CNT_W-1:0]  ldv_q, ldv_n;
  logic              ldv_en;
  logic              stb_q, stb_n;
  logic              prog, lcnt, lsts;

  assign prog = cmd.prog;
  assign lcnt = cmd.latch_cnt;
  assign lsts = cmd.latch_sts;

  // byte presented for a read in this cycle, by priority
  always_comb begin
    if (sts_v_q) begin
      rd_byte = sts_q;
    end else if (lat_q != ACC_LATCH) begin
      rd_byte = (lat_q == ACC_HI) ? snap_q[CNT_W-1:BYTE_W] : snap_q[BYTE_W-1:0];
    end else begin
      unique case (acc_q)
        ACC_HI:   rd_byte = live_count[CNT_W-1:BYTE_W];
        ACC_WORD: rd_byte = rd_hi_q ? live_count[CNT_W-1:BYTE_W] : live_count[BYTE_W-1:0];
        default:  rd_byte = live_count[BYTE_W-1:0];
      endcase
    end
  end

  // next state
  always_comb begin
    acc_n   = acc_q;
    mode_n  = mode_q;
    bcd_n   = bcd_q;
    wr_hi_n = wr_hi_q;
    rd_hi_n = rd_hi_q;
    wlo_n   = wlo_q;
    wlo_en  = 1'b0;
    snap_n  = snap_q;
    snap_en = 1'b0;
    lat_n   = lat_q;
    sts_v_n = sts_v_q;
    sts_n   = sts_q;
    sts_en  = 1'b0;
    ldv_n   = ldv_q;
    ldv_en  = 1'b0;
    stb_n   = 1'b0;

    if (data_rd) begin
      if (sts_v_q) begin
        sts_v_n = 1'b0;
      end else if (lat_q != ACC_LATCH) begin
        lat_n = (lat_q == ACC_WORD) ? ACC_HI : ACC_LATCH;
      end else if (acc_q == ACC_WORD) begin
        rd_hi_n = !rd_hi_q;
      end
    end

    if (data_wr) begin
      unique case (acc_q)
        ACC_LO: begin
          ldv_n  = {{BYTE_W{1'b0}}, wdata};
          ldv_en = 1'b1;
          stb_n  = 1'b1;
        end
        ACC_HI: begin
          ldv_n  = {wdata, {BYTE_W{1'b0}}};
          ldv_en = 1'b1;
          stb_n  = 1'b1;
        end
        default: begin
          if (!wr_hi_q) begin
            wlo_n   = wdata;
            wlo_en  = 1'b1;
            wr_hi_n = 1'b1;
          end else begin
            ldv_n   = {wdata, wlo_q};
            ldv_en  = 1'b1;
            stb_n   = 1'b1;
            wr_hi_n = 1'b0;
          end
        end
      endcase
    end

    if (prog) begin
      acc_n   = cmd.acc;
      mode_n  = cmd.mode;
      bcd_n   = cmd.bcd;
      wr_hi_n = 1'b0;
      rd_hi_n = 1'b0;
    end

    if (lcnt && (lat_q == ACC_LATCH)) begin
      snap_n  = live_count;
      snap_en = 1'b1;
      lat_n   = acc_q;
    end

    if (lsts && !sts_v_q) begin
      sts_n   = {cnt_out, 1'b0, acc_q, mode_q, bcd_q};
      sts_en  = 1'b1;
      sts_v_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= ACC_WORD;
      mode_q  <= '0;
      bcd_q   <= 1'b0;
      wr_hi_q <= 1'b0;
      rd_hi_q <= 1'b0;
      wlo_q   <= '0;
      snap_q  <= '0;
      lat_q   <= ACC_LATCH;
      sts_v_q <= 1'b0;
      sts_q   <= '0;
      ldv_q   <= '0;
      stb_q   <= 1'b0;
    end else begin
      acc_q   <= acc_n;
      mode_q  <= mode_n;
      bcd_q   <= bcd_n;
      wr_hi_q <= wr_hi_n;
      rd_hi_q <= rd_hi_n;
      lat_q   <= lat_n;
      sts_v_q <= sts_v_n;
      stb_q   <= stb_n;
      if (wlo_en)  wlo_q  <= wlo_n;
      if (snap_en) snap_q <= snap_n;
      if (sts_en)  sts_q  <= sts_n;
      if (ldv_en)  ldv_q  <= ldv_n;
    end
  end

  assign ld_value  = ldv_q;
  assign ld_strobe = stb_q;
  assign ld_mode   = mode_q;

  AST_LOAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(data_wr)); // R4
  AST_FIRST_BYTE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && acc_q == ACC_WORD && !wr_hi_q) |=> !stb_q); // R4
  AST_CFG_BY_CMD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({acc_q, mode_q, bcd_q}) |-> $past(prog)); // R2
  AST_SNAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q != ACC_LATCH && lcnt && !data_rd) |=> $stable(snap_q)); // R7
  AST_STATUS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_v_q && lsts) |=> $stable(sts_q)); // R10
  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_v_q && data_rd && !lcnt && !lsts) |=> (!sts_v_q && $stable(lat_q))); // R8
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           bus_addr,
  input  logic [BYTE_W-1:0]       bus_wdata,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  output logic [BYTE_W-1:0]       bus_rdata,
  output logic [NCH*CNT_W-1:0]    ld_value,
  output logic [NCH-1:0]          ld_strobe,
  output logic [NCH*MODE_W-1:0]   ld_mode,
  input  logic [NCH*CNT_W-1:0]    live_count,
  input  logic [NCH-1:0]          cnt_out
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  chan_cmd_t [NCH-1:0] cmd;
  logic [BYTE_W-1:0]   rd_byte [NCH];
  logic [BYTE_W-1:0]   rdata_q, rdata_n;

  tmr_cmd_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cmd       (cmd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic sel_wr, sel_rd;
    assign sel_wr = bus_wr && (bus_addr == AW'(g));
    assign sel_rd = bus_rd && (bus_addr == AW'(g));
    tmr_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd[g]),
      .data_wr    (sel_wr),
      .data_rd    (sel_rd),
      .wdata      (bus_wdata),
      .live_count (live_count[g*CNT_W +: CNT_W]),
      .cnt_out    (cnt_out[g]),
      .rd_byte    (rd_byte[g]),
      .ld_value   (ld_value[g*CNT_W +: CNT_W]),
      .ld_strobe  (ld_strobe[g]),
      .ld_mode    (ld_mode[g*MODE_W +: MODE_W])
    );
  end

  always_comb begin
    rdata_n = '1;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(i)) rdata_n = rd_byte[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_n;
  end

  assign bus_rdata = rdata_q;

  AST_CMD_PORT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CTRL_ADDR) |=> (bus_rdata == 8'hFF)); // R12
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R12
endmodule

// File: tb/sim_tmr_host_if.sv
`timescale 1ns/1ps
module sim_tmr_host_if;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic        wr, rd;
  logic [7:0]  rdata;
  logic [47:0] ld_value;
  logic [2:0]  ld_strobe;
  logic [8:0]  ld_mode;
  logic [15:0] live [NCH];
  logic [2:0]  outs;
  logic [47:0] live_count;

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  logic [2:0]  stb_seen;
  logic [47:0] val_seen;

  always #2.5 clk = ~clk;
  assign live_count = {live[2], live[1], live[0]};

  tmr_host_if #(.NCH(NCH), .AW(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr),
    .bus_rd(rd), .bus_rdata(rdata), .ld_value(ld_value), .ld_strobe(ld_strobe),
    .ld_mode(ld_mode), .live_count(live_count), .cnt_out(outs)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    stb_seen = ld_strobe; val_seen = ld_value;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    brd(a, d);
    check(req, {24'h0, d}, {24'h0, exp});
  endtask

  task automatic prog(input int ch, input int acc, input int mode, input int bcd);
    bwr(2'd3, {2'(ch), 2'(acc), 3'(mode), 1'(bcd)});
  endtask

  function automatic logic [2:0] norm(input int m);
    return (m >= 6) ? 3'(m - 4) : 3'(m);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0; outs = '0;
    for (int c = 0; c < NCH; c++) live[c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rdata", {24'h0, rdata}, 32'h0);
    check("R1 strobe", {29'h0, ld_strobe}, 32'h0);
    check("R1 mode", {23'h0, ld_mode}, 32'h0);
    rst_n = 1'b1;

    // R1: reset configuration seen through a status capture of all channels
    outs = 3'b101;
    bwr(2'd3, 8'hEE);
    for (int c = 0; c < NCH; c++)
      rd_chk("R1 status", 2'(c), outs[c] ? 8'hB0 : 8'h30);

    // R2 / R3 / R10: configuration sweep, read back through status
    for (int c = 0; c < NCH; c++)
      for (int a = 1; a < 4; a++)
        for (int m = 0; m < 8; m++)
          for (int b = 0; b < 2; b++) begin
            prog(c, a, m, b);
            check(m >= 6 ? "R3 mode out" : "R2 mode out", {29'h0, ld_mode[c*3 +: 3]}, {29'h0, norm(m)});
            outs[c] = 1'((m + b) & 1);
            bwr(2'd3, 8'hE0 | 8'(1 << (c + 1)));
            rd_chk("R10 status fields", 2'(c), {outs[c], 1'b0, 2'(a), norm(m), 1'(b)});
          end

    // R5: single byte loads
    for (int c = 0; c < NCH; c++) begin
      prog(c, 1, 0, 0);
      for (int v = 0; v < 256; v += 51) begin
        bwr(2'(c), 8'(v));
        check("R5 lo strobe", {29'h0, stb_seen}, 32'(1 << c));
        check("R5 lo value", {16'h0, val_seen[c*16 +: 16]}, 32'(v));
      end
      prog(c, 2, 0, 0);
      for (int v = 7; v < 256; v += 62) begin
        bwr(2'(c), 8'(v));
        check("R5 hi strobe", {29'h0, stb_seen}, 32'(1 << c));
        check("R5 hi value", {16'h0, val_seen[c*16 +: 16]}, 32'(v << 8));
      end
    end

    // R4: two-byte loads
    for (int c = 0; c < NCH; c++) begin
      prog(c, 3, 2, 0);
      for (int k = 0; k < 5; k++) begin
        logic [15:0] v;
        v = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'(k * 16'h3A5F);
        bwr(2'(c), v[7:0]);
        check("R4 no strobe on first", {29'h0, stb_seen}, 32'h0);
        bwr(2'(c), v[15:8]);
        check("R4 strobe", {29'h0, stb_seen}, 32'(1 << c));
        check("R4 value", {16'h0, val_seen[c*16 +: 16]}, {16'h0, v});
      end
    end

    // R13: reconfiguration resets write and read pointers
    prog(1, 3, 0, 0);
    bwr(2'd1, 8'h11);
    prog(1, 3, 0, 0);
    bwr(2'd1, 8'h22);
    check("R13 first byte again", {29'h0, stb_seen}, 32'h0);
    bwr(2'd1, 8'h33);
    check("R13 value", {16'h0, val_seen[31:16]}, 32'h3322);
    live[1] = 16'hBEEF;
    rd_chk("R13 read low", 2'd1, 8'hEF);
    prog(1, 3, 0, 0);
    rd_chk("R13 read low after reprogram", 2'd1, 8'hEF);

    // R11: live reads
    for (int c = 0; c < NCH; c++) begin
      live[c] = 16'hA5C3 + 16'(c);
      prog(c, 3, 0, 0);
      rd_chk("R11 word low", 2'(c), 8'hC3 + 8'(c));
      rd_chk("R11 word high", 2'(c), 8'hA5);
      rd_chk("R11 word low again", 2'(c), 8'hC3 + 8'(c));
      prog(c, 1, 0, 0);
      rd_chk("R11 lo", 2'(c), 8'hC3 + 8'(c));
      rd_chk("R11 lo repeat", 2'(c), 8'hC3 + 8'(c));
      prog(c, 2, 0, 0);
      rd_chk("R11 hi", 2'(c), 8'hA5);
      rd_chk("R11 hi repeat", 2'(c), 8'hA5);
    end

    // R6: count freeze in each access format
    for (int c = 0; c < NCH; c++) begin
      prog(c, 3, 0, 0);
      live[c] = 16'h1234;
      bwr(2'd3, {2'(c), 6'h00});
      live[c] = 16'h5678;
      rd_chk("R6 word low", 2'(c), 8'h34);
      rd_chk("R6 word high", 2'(c), 8'h12);
      rd_chk("R6 live after", 2'(c), 8'h78);
      prog(c, 1, 0, 0);
      bwr(2'd3, {2'(c), 6'h00});
      live[c] = 16'h9ABC;
      rd_chk("R6 lo snap", 2'(c), 8'h78);
      rd_chk("R6 lo live", 2'(c), 8'hBC);
      prog(c, 2, 0, 0);
      bwr(2'd3, {2'(c), 6'h00});
      live[c] = 16'hDEF0;
      rd_chk("R6 hi snap", 2'(c), 8'h9A);
      rd_chk("R6 hi live", 2'(c), 8'hDE);
    end

    // R7: second freeze ignored while pending
    prog(0, 3, 0, 0);
    live[0] = 16'h1111;
    bwr(2'd3, 8'h00);
    live[0] = 16'h2222;
    bwr(2'd3, 8'h00);
    rd_chk("R7 kept low", 2'd0, 8'h11);
    rd_chk("R7 kept high", 2'd0, 8'h11);
    rd_chk("R7 live after", 2'd0, 8'h22);

    // R8: status before count
    prog(2, 3, 4, 1);
    outs[2] = 1'b1;
    live[2] = 16'h4321;
    bwr(2'd3, 8'hC8);
    live[2] = 16'h0000;
    rd_chk("R8 status first", 2'd2, {1'b1, 1'b0, 2'b11, 3'd4, 1'b1});
    rd_chk("R8 count low", 2'd2, 8'h21);
    rd_chk("R8 count high", 2'd2, 8'h43);

    // R9: capture of channels 0 and 2 only
    for (int c = 0; c < NCH; c++) prog(c, 3, 0, 0);
    live[0] = 16'h0A0B; live[1] = 16'h0C0D; live[2] = 16'h0E0F;
    bwr(2'd3, 8'hDA);
    live[0] = 16'h7777; live[1] = 16'h6655; live[2] = 16'h7777;
    rd_chk("R9 unselected live", 2'd1, 8'h55);
    rd_chk("R9 ch0 snap low", 2'd0, 8'h0B);
    rd_chk("R9 ch0 snap high", 2'd0, 8'h0A);
    rd_chk("R9 ch2 snap low", 2'd2, 8'h0F);
    rd_chk("R9 ch2 snap high", 2'd2, 8'h0E);

    // R10: status not overwritten while pending
    prog(1, 1, 5, 0);
    outs[1] = 1'b0;
    bwr(2'd3, 8'hE4);
    outs[1] = 1'b1;
    prog(1, 2, 3, 1);
    bwr(2'd3, 8'hE4);
    rd_chk("R10 kept status", 2'd1, {1'b0, 1'b0, 2'b01, 3'd5, 1'b0});
    live[1] = 16'h8642;
    rd_chk("R10 consumed", 2'd1, 8'h86);

    // R12: command port reads 0xFF and disturbs nothing
    outs[0] = 1'b1;
    prog(0, 1, 1, 0);
    bwr(2'd3, 8'hE2);
    rd_chk("R12 ff", 2'd3, 8'hFF);
    rd_chk("R12 ff again", 2'd3, 8'hFF);
    rd_chk("R12 status intact", 2'd0, {1'b1, 1'b0, 2'b01, 3'd1, 1'b0});

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule